// File: doc/BRIEF.md
# Instruction/Data L1 Coherence Controller

This block tracks, for every line of a small address window, whether the line sits in the level-0 instruction buffer, in the level-1 instruction cache and in the level-1 data cache. It keeps those copies consistent with each other and with a unified level-2 cache. The core issues instruction-fetch, load and store requests, one at a time, each carrying a byte address. For every request the controller works out which steps are needed. It then issues write-back, fill and write-permission commands to the level-2 cache one at a time, each over a request/acknowledge handshake. When the request is finished it pulses a completion flag. Only line states are modelled here, not data.

The level-1 instruction copy and a modified data copy of the same line are kept mutually exclusive in hardware. A store removes the instruction copy. A fetch forces a modified data line back to level-2 before the instruction cache is filled. Code that rewrites itself therefore needs no explicit flush. A fetch that misses the level-0 buffer also pulls in the next sequential line.

Top module: `idc_coherence_ctrl`

## Requirements
- R1: After reset every line is absent from I0 and I1 and invalid in D1. `req_ready_o` is 1, and `l2_req_o` and `done_o` are 0.
- R2: While `l2_req_o` is 1 and `l2_ack_i` is 0, the command and line stay unchanged. Only one command is outstanding. The next step starts in the cycle after the acknowledge.
- R3: No line is ever valid in I1 while it is modified in D1.
- R4: I0 holds a line only while I1 holds it. Removing a line from I1 also removes it from I0.
- R5: A fetch that misses I0 and I1 on a line that is modified in D1 issues a write-back (command 0) and then an instruction fill (command 1) for that line. D1 is then clean, so a later store issues a permission upgrade (command 4).
- R6: A load to a line invalid in D1 issues a data fill (command 2) and leaves the line clean in D1. The I0 and I1 state is left unchanged.
- R7: A store to a line invalid in D1 first removes any I1/I0 copy and then issues a fill-for-ownership (command 3). The line ends up modified in D1.
- R8: A store to a line clean in D1 removes any I1/I0 copy and issues only a permission upgrade (command 4), with no data fill. The line ends up modified.
- R9: Some requests are hits: a fetch that hits I0, a load with D1 clean or modified, and a store with D1 modified. A hit issues no command and raises `done_o` in the cycle after it is accepted. `done_o` always lasts exactly one cycle.
- R10: A fetch that misses I0 on line N is followed by a fetch-like step on line N+1, taken modulo the window. That step does nothing if N+1 is already in I0. It writes back first if N+1 is modified in D1.
- R11: The line address is `req_addr_i[ADDR_W-1:6]` (64-byte lines). Bits 5:0 are ignored. Operation codes are 0 fetch, 1 load and 2 store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid, accepted when `req_ready_o` is 1 |
| req_op_i | input | 2 | Operation: 0 fetch, 1 load, 2 store |
| req_addr_i | input | LINE_W+OFFS_W | Byte address of the request |
| req_ready_o | output | 1 | Controller idle and able to accept |
| done_o | output | 1 | One-cycle pulse when a request completes |
| l2_req_o | output | 1 | Level-2 command valid |
| l2_cmd_o | output | 3 | 0 write-back, 1 instruction fill, 2 data fill, 3 fill for ownership, 4 upgrade |
| l2_line_o | output | LINE_W | Line address of the command |
| l2_ack_i | input | 1 | Level-2 acknowledge of the current command |

## Verification
On every cycle, assertions check the exclusivity and inclusion invariants of every stored line. They also check that a command stays stable while it waits and that a write-back is always followed by an instruction fill of the same line. Further assertions check that ownership requests never see an instruction copy and that the completion pulse lasts one cycle. Only the bench scenarios can show that each request type picks the right command sequence. The same goes for state left behind by one request and seen in the commands of a later one, for prefetch wrap-around, and for hit latency. A behavioural model covers these with directed cases and a long random run under varying acknowledge delays.

// File: rtl/idc_pkg.sv
package idc_pkg;
  typedef enum logic [1:0] {OP_FETCH = 2'd0, OP_LOAD = 2'd1, OP_STORE = 2'd2} op_e;
  typedef enum logic [1:0] {D_INV = 2'd0, D_CLN = 2'd1, D_MOD = 2'd2} dstate_e;
  typedef enum logic [2:0] {
    C_WRBACK = 3'd0, C_FILL_INST = 3'd1, C_FILL_DATA = 3'd2,
    C_FILL_OWN = 3'd3, C_UPGRADE = 3'd4
  } cmd_e;
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_L2, S_DONE} seq_e;
endpackage

// File: rtl/idc_tag_table.sv
module idc_tag_table
  import idc_pkg::*;
#(
  parameter int LINE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  input  logic              set_i0_i,
  input  logic              fill_i_i,
  input  logic              inval_i_i,
  input  logic              d1_we_i,
  input  dstate_e           d1_val_i,
  output logic              i0_o,
  output logic              i1_o,
  output dstate_e           d1_o
);
  localparam int N_LINES = 1 << LINE_W;

  logic [N_LINES-1:0] i0_v, i1_v;
  dstate_e            d1_v [N_LINES];

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic    i0_r, i1_r;
    dstate_e d1_r;
    logic    sel;
    assign sel = (line_i == LINE_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        i0_r <= 1'b0;
        i1_r <= 1'b0;
        d1_r <= D_INV;
      end else if (sel) begin
        if (inval_i_i) begin
          i0_r <= 1'b0;
          i1_r <= 1'b0;
        end else if (fill_i_i) begin
          i0_r <= 1'b1;
          i1_r <= 1'b1;
        end else if (set_i0_i) begin
          i0_r <= 1'b1;
        end
        if (d1_we_i) d1_r <= d1_val_i;
      end
    end

    assign i0_v[g] = i0_r;
    assign i1_v[g] = i1_r;
    assign d1_v[g] = d1_r;

    a_r3_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(i1_r && d1_r == D_MOD));
    a_r4_incl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      i0_r |-> i1_r);
  end

  assign i0_o = i0_v[line_i];
  assign i1_o = i1_v[line_i];
  assign d1_o = d1_v[line_i];

  // instruction fill must never land on a modified data line
  a_r3_no_fill_over_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i_i |-> d1_o != D_MOD);
endmodule

// File: rtl/idc_seq.sv
module idc_seq
  import idc_pkg::*;
#(
  parameter int LINE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  op_e               req_op_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic              i0_i,
  input  logic              i1_i,
  input  dstate_e           d1_i,
  input  logic              l2_ack_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic              l2_req_o,
  output cmd_e              l2_cmd_o,
  output logic [LINE_W-1:0] l2_line_o,
  output logic [LINE_W-1:0] act_line_o,
  output logic              set_i0_o,
  output logic              fill_i_o,
  output logic              inval_i_o,
  output logic              d1_we_o,
  output dstate_e           d1_val_o
);
  seq_e              state_q, nxt_state;
  cmd_e              cmd_q, nxt_cmd;
  op_e               op_q, nxt_op, eval_op;
  logic [LINE_W-1:0] line_q, nxt_line;
  logic              pf_q, nxt_pf, eval_pf;

  assign act_line_o = (state_q == S_IDLE) ? req_line_i : line_q;
  assign eval_op    = (state_q == S_IDLE) ? req_op_i : op_q;
  assign eval_pf    = (state_q == S_IDLE) ? 1'b0 : pf_q;

  always_comb begin
    nxt_state = state_q;
    nxt_cmd   = cmd_q;
    nxt_op    = op_q;
    nxt_line  = line_q;
    nxt_pf    = pf_q;
    set_i0_o  = 1'b0;
    fill_i_o  = 1'b0;
    inval_i_o = 1'b0;
    d1_we_o   = 1'b0;
    d1_val_o  = D_INV;
    case (state_q)
      S_IDLE, S_EVAL: begin
        if (state_q == S_EVAL || req_valid_i) begin
          if (state_q == S_IDLE) begin
            nxt_op   = req_op_i;
            nxt_line = req_line_i;
            nxt_pf   = 1'b0;
          end
          case (eval_op)
            OP_FETCH: begin
              if (i0_i) begin
                nxt_state = S_DONE;
              end else if (i1_i) begin
                set_i0_o = 1'b1;
                if (eval_pf) nxt_state = S_DONE;
                else begin
                  nxt_state = S_EVAL;
                  nxt_line  = act_line_o + LINE_W'(1);
                  nxt_pf    = 1'b1;
                end
              end else begin
                nxt_state = S_L2;
                nxt_cmd   = (d1_i == D_MOD) ? C_WRBACK : C_FILL_INST;
              end
            end
            OP_LOAD: begin
              if (d1_i == D_INV) begin
                nxt_state = S_L2;
                nxt_cmd   = C_FILL_DATA;
              end else nxt_state = S_DONE;
            end
            OP_STORE: begin
              if (d1_i == D_MOD) nxt_state = S_DONE;
              else begin
                inval_i_o = i1_i;  // instruction copy goes before ownership
                nxt_state = S_L2;
                nxt_cmd   = (d1_i == D_CLN) ? C_UPGRADE : C_FILL_OWN;
              end
            end
            default: nxt_state = S_DONE;
          endcase
        end
      end
      S_L2: begin
        if (l2_ack_i) begin
          case (cmd_q)
            C_WRBACK: begin
              d1_we_o  = 1'b1;
              d1_val_o = D_CLN;
              nxt_cmd  = C_FILL_INST;
            end
            C_FILL_INST: begin
              fill_i_o = 1'b1;
              if (pf_q) nxt_state = S_DONE;
              else begin
                nxt_state = S_EVAL;
                nxt_line  = line_q + LINE_W'(1);
                nxt_pf    = 1'b1;
              end
            end
            C_FILL_DATA: begin
              d1_we_o   = 1'b1;
              d1_val_o  = D_CLN;
              nxt_state = S_DONE;
            end
            default: begin
              d1_we_o   = 1'b1;
              d1_val_o  = D_MOD;
              nxt_state = S_DONE;
            end
          endcase
        end
      end
      default: nxt_state = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cmd_q   <= C_WRBACK;
      op_q    <= OP_FETCH;
      line_q  <= '0;
      pf_q    <= 1'b0;
    end else begin
      state_q <= nxt_state;
      cmd_q   <= nxt_cmd;
      op_q    <= nxt_op;
      line_q  <= nxt_line;
      pf_q    <= nxt_pf;
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign l2_req_o    = (state_q == S_L2);
  assign l2_cmd_o    = cmd_q;
  assign l2_line_o   = line_q;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_o && !l2_ack_i |=> l2_req_o && $stable(l2_cmd_o) && $stable(l2_line_o));
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !l2_req_o);
  a_r5_wb_then_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_o && l2_cmd_o == C_WRBACK && l2_ack_i |=>
      l2_req_o && l2_cmd_o == C_FILL_INST && $stable(l2_line_o));
  a_r7_own_no_icopy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_o && (l2_cmd_o == C_FILL_OWN || l2_cmd_o == C_UPGRADE) |-> !i1_i);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);
endmodule

// File: rtl/idc_coherence_ctrl.sv
module idc_coherence_ctrl
  import idc_pkg::*;
#(
  parameter int LINE_W = 4,
  parameter int OFFS_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [1:0]               req_op_i,
  input  logic [LINE_W+OFFS_W-1:0] req_addr_i,
  output logic                     req_ready_o,
  output logic                     done_o,
  output logic                     l2_req_o,
  output logic [2:0]               l2_cmd_o,
  output logic [LINE_W-1:0]        l2_line_o,
  input  logic                     l2_ack_i
);
  localparam int ADDR_W = LINE_W + OFFS_W;

  logic [LINE_W-1:0] req_line, act_line;
  logic              unused_offs;
  logic              i0, i1, set_i0, fill_i, inval_i, d1_we;
  dstate_e           d1, d1_val;
  cmd_e              cmd;

  assign req_line    = req_addr_i[ADDR_W-1:OFFS_W];
  assign unused_offs = ^req_addr_i[OFFS_W-1:0];
  assign l2_cmd_o    = cmd;

  idc_seq #(.LINE_W(LINE_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_op_i   (op_e'(req_op_i)),
    .req_line_i (req_line),
    .i0_i       (i0),
    .i1_i       (i1),
    .d1_i       (d1),
    .l2_ack_i   (l2_ack_i),
    .req_ready_o(req_ready_o),
    .done_o     (done_o),
    .l2_req_o   (l2_req_o),
    .l2_cmd_o   (cmd),
    .l2_line_o  (l2_line_o),
    .act_line_o (act_line),
    .set_i0_o   (set_i0),
    .fill_i_o   (fill_i),
    .inval_i_o  (inval_i),
    .d1_we_o    (d1_we),
    .d1_val_o   (d1_val)
  );

  idc_tag_table #(.LINE_W(LINE_W)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (act_line),
    .set_i0_i (set_i0),
    .fill_i_i (fill_i),
    .inval_i_i(inval_i),
    .d1_we_i  (d1_we),
    .d1_val_i (d1_val),
    .i0_o     (i0),
    .i1_o     (i1),
    .d1_o     (d1)
  );
endmodule

// File: tb/idc_coherence_ctrl_test.sv
`timescale 1ns/1ps
module idc_coherence_ctrl_test;
  localparam int LW = 4;
  localparam int OW = 6;
  localparam int NL = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [LW+OW-1:0] req_addr = '0;
  logic          l2_ack = 1'b0;
  logic          req_ready, done, l2_req;
  logic [2:0]    l2_cmd;
  logic [LW-1:0] l2_line;

  always #4 clk = ~clk;

  idc_coherence_ctrl #(.LINE_W(LW), .OFFS_W(OW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_ready_o(req_ready), .done_o(done),
    .l2_req_o(l2_req), .l2_cmd_o(l2_cmd), .l2_line_o(l2_line), .l2_ack_i(l2_ack)
  );

  int checks = 0, fails = 0, cyc = 0;
  int m_i0[NL], m_i1[NL], m_d1[NL];  // d1: 0 inv, 1 clean, 2 modified
  int q_cmd[$], q_line[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(0, "WDOG", "watchdog cycles", cyc, 150000);
        finish_run();
      end
    end
  end

  task automatic m_fetch(int ln);
    if (m_i0[ln] != 0) return;
    if (m_i1[ln] != 0) begin m_i0[ln] = 1; return; end
    if (m_d1[ln] == 2) begin q_cmd.push_back(0); q_line.push_back(ln); m_d1[ln] = 1; end
    q_cmd.push_back(1); q_line.push_back(ln);
    m_i1[ln] = 1; m_i0[ln] = 1;
  endtask

  task automatic model(int op, int ln, output bit fast);
    bit miss;
    q_cmd.delete(); q_line.delete();
    fast = 1'b0;
    case (op)
      0: begin
        miss = (m_i0[ln] == 0);
        fast = !miss;
        m_fetch(ln);
        if (miss) m_fetch((ln + 1) % NL);
      end
      1: begin
        fast = (m_d1[ln] != 0);
        if (m_d1[ln] == 0) begin q_cmd.push_back(2); q_line.push_back(ln); m_d1[ln] = 1; end
      end
      default: begin
        fast = (m_d1[ln] == 2);
        if (m_d1[ln] != 2) begin
          m_i1[ln] = 0; m_i0[ln] = 0;
          q_cmd.push_back(m_d1[ln] == 1 ? 4 : 3); q_line.push_back(ln);
          m_d1[ln] = 2;
        end
      end
    endcase
  endtask

  task automatic run(int op, int ln, int lowb, int dly, string req);
    bit fast, fin;
    int ec;
    model(op, ln, fast);
    @(negedge clk);
    check(req_ready == 1'b1, req, "ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_op    = op[1:0];
    req_addr  = {ln[LW-1:0], lowb[OW-1:0]};
    @(negedge clk);
    req_valid = 1'b0;
    if (fast) check(done == 1'b1, "R9", "hit completion latency", done, 1);
    fin = 1'b0;
    for (int k = 0; k < 80 && !fin; k++) begin
      if (done) begin
        check(q_cmd.size() == 0, req, "commands missing at done", q_cmd.size(), 0);
        fin = 1'b1;
      end else if (l2_req) begin
        if (q_cmd.size() == 0) begin
          check(0, req, "unexpected l2 command", l2_cmd, -1);
          ec = l2_cmd;
        end else begin
          ec = q_cmd.pop_front();
          check(l2_cmd == ec, req, "l2 command", l2_cmd, ec);
          check(l2_line == q_line[0], req, "l2 line", l2_line, q_line[0]);
          void'(q_line.pop_front());
        end
        if (dly > 0) begin
          repeat (dly) @(negedge clk);
          check(l2_req && l2_cmd == ec, "R2", "command held while waiting", l2_cmd, ec);
        end
        l2_ack = 1'b1;
        @(negedge clk);
        l2_ack = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    if (!fin) check(0, req, "request never completed", 0, 1);
    else begin
      @(negedge clk);
      check(!done && req_ready, "R9", "done lasts one cycle", done, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin m_i0[i] = 0; m_i1[i] = 0; m_d1[i] = 0; end
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    check(l2_req == 1'b0, "R1", "l2_req in reset", l2_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(l2_req == 1'b0, "R1", "l2_req after reset", l2_req, 0);

    run(0, 3, 17, 0, "R1");   // cold fetch: fill 3, prefetch 4 (R10)
    run(0, 3, 0, 1, "R9");    // I0 hit
    run(1, 3, 5, 2, "R6");    // data fill, I untouched
    run(0, 3, 63, 0, "R6");   // still an I0 hit
    run(2, 4, 9, 1, "R7");    // invalidate I, fill for ownership
    run(0, 4, 1, 0, "R5");    // write-back then fill, prefetch 5 (R10)
    run(2, 3, 2, 0, "R8");    // clean data line: upgrade only
    run(2, 3, 44, 0, "R9");   // store hit on modified line
    run(0, 3, 0, 3, "R5");    // write-back 3, fill 3, line 4 already in I0
    run(2, 3, 0, 0, "R5");    // D1 now clean: upgrade
    run(1, 3, 30, 0, "R9");   // load hit
    run(0, 15, 7, 1, "R10");  // prefetch wraps to line 0
    run(2, 8, 0, 0, "R7");
    run(0, 7, 0, 2, "R10");   // prefetch target modified: write-back first
    run(1, 9, 63, 0, "R11");  // offset bits ignored
    run(1, 9, 0, 0, "R11");

    for (int i = 0; i < 300; i++)
      run($urandom_range(0, 2), $urandom_range(0, NL - 1), $urandom_range(0, 63),
          $urandom_range(0, 3), "R2");

    finish_run();
  end
endmodule